// File: doc/BRIEF.md
# Two-Channel Burst Pulse Generator

This block drives two independent pulse outputs. Each output alternates between a high phase and a low phase, and the length of each phase is a count of timebase ticks. A tick is a single-cycle strobe that comes from an outside divider; in normal use it arrives once every 100 microseconds. Each channel also holds a burst length. A nonzero burst length makes the channel stop after that many complete pulses. A burst length of zero makes it repeat until software stops it.

Configuration arrives as write strobes from a command decoder: an 8-bit command code and a 16-bit data word. One command writes a shared enable mask that starts and stops both channels. The current mask is always visible on an output port, so software can read it, change one bit and write it back. When a burst finishes, the channel clears its own bit in the mask.

Top module: `pwm_burst_top`

## Requirements
- R1: After reset both pulse outputs are low and the enable mask reads 0.
- R2: Command code 0x10+2n writes the high period of channel n, 0x11+2n writes its low period, 0x14+n writes its burst length, and 0x1F writes the enable mask, with data bit n enabling channel n. All other codes change nothing.
- R3: When a mask write moves bit n from 0 to 1, channel n starts in its high phase. The high phase lasts high-period ticks and the low phase lasts low-period ticks, and the two phases alternate.
- R4: A period value of 0 behaves exactly like a period value of 1.
- R5: With a nonzero burst length N, channel n emits exactly N pulses. At the tick that ends the N-th low phase, its mask bit clears and its output stays low.
- R6: With a burst length of 0, the channel repeats pulses for as long as its mask bit is set.
- R7: The enable-mask output shows the last written mask from the cycle after the write. Clearing a bit drives that channel's output low from the next cycle.
- R8: Phase counting advances only in cycles where the tick input is high. The outputs hold their value between ticks.
- R9: The two channels run independently; the settings of one never change the waveform of the other.
- R10: Writing a mask whose bit n is already 1 does not restart channel n; its waveform continues undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase strobe, one cycle wide |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_code_i | input | 8 | Command code |
| cmd_data_i | input | 16 | Command data word |
| en_mask_o | output | 2 | Current enable mask, bit n for channel n |
| pwm_o | output | 2 | Pulse outputs, bit n for channel n |

## Verification
The hardest case to reach is the tick that ends the final low phase of a burst. At that tick the mask bit must clear, and the output must stay low instead of starting another high phase. It must also happen at the same moment whichever channel finishes first. The stimulus reaches it with random short periods (zero included) and burst lengths of 0 to 3 on both channels together, so bursts end at different tick counts. Random idle gaps between ticks show that nothing moves without a tick. Directed steps cover a mask rewrite in the middle of a run, a disable in the middle of a high phase, and writes with unused command codes.

// File: rtl/pwm_burst_pkg.sv
package pwm_burst_pkg;
  localparam int unsigned CODE_W = 8;
  localparam logic [CODE_W-1:0] CODE_HI_BASE    = 8'h10;
  localparam logic [CODE_W-1:0] CODE_BURST_BASE = 8'h14;
  localparam logic [CODE_W-1:0] CODE_MASK       = 8'h1F;
endpackage

// File: rtl/pwm_cmd_decode.sv
module pwm_cmd_decode
  import pwm_burst_pkg::*;
#(
  parameter int unsigned NCH = 2
) (
  input  logic              we_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [NCH-1:0]    hi_we_o,
  output logic [NCH-1:0]    lo_we_o,
  output logic [NCH-1:0]    burst_we_o,
  output logic              mask_we_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_dec
    always_comb begin
      hi_we_o[g]    = we_i && (code_i == CODE_W'(CODE_HI_BASE + 2 * g));
      lo_we_o[g]    = we_i && (code_i == CODE_W'(CODE_HI_BASE + 2 * g + 1));
      burst_we_o[g] = we_i && (code_i == CODE_W'(CODE_BURST_BASE + g));
    end
  end

  assign mask_we_o = we_i && (code_i == CODE_MASK);
endmodule

// File: rtl/pwm_burst_chan.sv
module pwm_burst_chan #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         en_i,
  input  logic         start_i,
  input  logic         hi_we_i,
  input  logic         lo_we_i,
  input  logic         burst_we_i,
  input  logic [W-1:0] wdata_i,
  output logic         pwm_o,
  output logic         done_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] hi_q, hi_n, lo_q, lo_n, bcnt_q, bcnt_n;
  logic [W-1:0] ctr_q, ctr_n, rem_q, rem_n;
  logic         high_q, high_n;
  logic [W-1:0] eff_hi, eff_lo;
  logic         step, phase_end, last_pulse;

  assign eff_hi     = (hi_q == '0) ? ONE : hi_q;
  assign eff_lo     = (lo_q == '0) ? ONE : lo_q;
  assign step       = en_i && tick_i && !start_i;
  assign phase_end  = (ctr_q == ONE);
  assign last_pulse = (rem_q == ONE);
  assign done_o     = step && phase_end && !high_q && last_pulse;
  assign pwm_o      = en_i && high_q;

  always_comb begin
    hi_n   = hi_q;
    lo_n   = lo_q;
    bcnt_n = bcnt_q;
    ctr_n  = ctr_q;
    rem_n  = rem_q;
    high_n = high_q;
    if (hi_we_i)    hi_n   = wdata_i;
    if (lo_we_i)    lo_n   = wdata_i;
    if (burst_we_i) bcnt_n = wdata_i;
    if (start_i) begin
      high_n = 1'b1;
      ctr_n  = eff_hi;
      rem_n  = bcnt_q;
    end else if (step) begin
      if (!phase_end) begin
        ctr_n = ctr_q - ONE;
      end else if (high_q) begin
        high_n = 1'b0;
        ctr_n  = eff_lo;
      end else if (!last_pulse) begin
        high_n = 1'b1;
        ctr_n  = eff_hi;
        if (rem_q != '0) rem_n = rem_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= ONE;
      lo_q   <= ONE;
      bcnt_q <= '0;
      ctr_q  <= ONE;
      rem_q  <= '0;
      high_q <= 1'b0;
    end else begin
      hi_q   <= hi_n;
      lo_q   <= lo_n;
      bcnt_q <= bcnt_n;
      ctr_q  <= ctr_n;
      rem_q  <= rem_n;
      high_q <= high_n;
    end
  end

  // R4: a running channel never holds a zero count
  p_ctr_live_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> ctr_q != '0);
  // R8: without a tick the phase state does not move
  p_hold_no_tick_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_i && !start_i) |=> ($stable(ctr_q) && $stable(high_q)));
  // R3: a start lands in the high phase with the burst length loaded
  p_start_high_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (high_q && rem_q == $past(bcnt_q)));
endmodule

// File: rtl/pwm_burst_top.sv
module pwm_burst_top
  import pwm_burst_pkg::*;
#(
  parameter int unsigned NCH = 2,
  parameter int unsigned W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              cmd_we_i,
  input  logic [CODE_W-1:0] cmd_code_i,
  input  logic [W-1:0]      cmd_data_i,
  output logic [NCH-1:0]    en_mask_o,
  output logic [NCH-1:0]    pwm_o
);
  logic [NCH-1:0] hi_we, lo_we, burst_we, start, done;
  logic [NCH-1:0] mask_q, mask_n;
  logic           mask_we;

  pwm_cmd_decode #(.NCH(NCH)) u_dec (
    .we_i       (cmd_we_i),
    .code_i     (cmd_code_i),
    .hi_we_o    (hi_we),
    .lo_we_o    (lo_we),
    .burst_we_o (burst_we),
    .mask_we_o  (mask_we)
  );

  assign start = mask_we ? (cmd_data_i[NCH-1:0] & ~mask_q) : '0;

  always_comb begin
    if (mask_we) mask_n = cmd_data_i[NCH-1:0];
    else         mask_n = mask_q & ~done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_n;
  end

  assign en_mask_o = mask_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_burst_chan #(.W(W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .en_i       (mask_q[g]),
      .start_i    (start[g]),
      .hi_we_i    (hi_we[g]),
      .lo_we_i    (lo_we[g]),
      .burst_we_i (burst_we[g]),
      .wdata_i    (cmd_data_i),
      .pwm_o      (pwm_o[g]),
      .done_o     (done[g])
    );

    // R5: a finished burst drops its enable bit
    p_done_clears_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (done[g] && !mask_we) |=> !en_mask_o[g]);
  end

  // R7: the mask output follows each mask write
  p_mask_wr_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> en_mask_o == $past(cmd_data_i[NCH-1:0]));
  // R2: one command code selects at most one register
  p_one_target_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hi_we, lo_we, burst_we, mask_we}));
endmodule

// File: tb/sim_pwm_burst_top.sv
`timescale 1ns/1ps
module sim_pwm_burst_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  code = '0;
  logic [15:0] data = '0;
  logic [1:0]  en_mask, pwm;
  int          errors = 0;
  int          checks = 0;
  int          hp[2], lp[2], bn[2];
  bit          on[2];
  int          k;

  always #4 clk = ~clk;

  pwm_burst_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cmd_we_i(we),
    .cmd_code_i(code), .cmd_data_i(data), .en_mask_o(en_mask), .pwm_o(pwm)
  );

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int exp_level(int kk, int h, int l, int n, bit en);
    int p;
    if (!en) return 0;
    p = eff(h) + eff(l);
    if (n != 0 && kk >= n * p) return 0;
    return ((kk % p) < eff(h)) ? 1 : 0;
  endfunction

  function automatic int exp_on(int kk, int h, int l, int n, bit en);
    if (!en) return 0;
    if (n != 0 && kk >= n * (eff(h) + eff(l))) return 0;
    return 1;
  endfunction

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (k=%0d)", req, act, expv, k);
    end
  endtask

  task automatic wr(input logic [7:0] c, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; code = c; data = d;
    @(negedge clk);
    we = 1'b0; code = '0; data = '0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic check_all(string req);
    for (int c = 0; c < 2; c++) begin
      check(req, pwm[c], exp_level(k, hp[c], lp[c], bn[c], on[c]));
      check(req, en_mask[c], exp_on(k, hp[c], lp[c], bn[c], on[c]));
    end
  endtask

  task automatic config_ch(int c, int h, int l, int n);
    hp[c] = h; lp[c] = l; bn[c] = n;
    wr(8'(8'h10 + 2 * c), 16'(h));
    wr(8'(8'h11 + 2 * c), 16'(l));
    wr(8'(8'h14 + c), 16'(n));
  endtask

  task automatic start_mask(logic [1:0] m);
    on[0] = m[0]; on[1] = m[1]; k = 0;
    wr(8'h1F, {14'd0, m});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_1234);
    k = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", pwm, 0);
    check("R1", en_mask, 0);

    // R3 R6 directed: ch0 hi=2 lo=3 continuous; R9 ch1 hi=1 lo=1 burst 2
    config_ch(0, 2, 3, 0);
    config_ch(1, 1, 1, 2);
    start_mask(2'b11);
    check_all("R3");
    for (int t = 0; t < 14; t++) begin
      do_tick(); k++;
      check_all("R5 R6 R9");
    end

    // R10: rewrite mask with ch0 already on, no restart
    wr(8'h1F, 16'h0001);
    on[1] = 1'b0;
    check_all("R10");
    do_tick(); k++;
    check_all("R10");

    // R7: disable ch0 in the middle of a run
    wr(8'h1F, 16'h0000);
    on[0] = 1'b0;
    check("R7", pwm, 0);
    check("R7", en_mask, 0);

    // R2 R4 directed: period zero and ignored codes
    config_ch(0, 0, 0, 3);
    config_ch(1, 0, 2, 1);
    wr(8'h16, 16'h0005);
    wr(8'h0E, 16'h0007);
    wr(8'h20, 16'h0009);
    wr(8'h1E, 16'h0003);
    check("R2", en_mask, 0);
    start_mask(2'b11);
    for (int t = 0; t < 8; t++) begin
      do_tick(); k++;
      check_all("R2 R4");
    end

    // random stimulus
    for (int it = 0; it < 40; it++) begin
      logic [1:0] m;
      int ticks;
      wr(8'h1F, 16'h0000);
      on[0] = 1'b0; on[1] = 1'b0;
      check("R7", en_mask, 0);
      for (int c = 0; c < 2; c++)
        config_ch(c, int'($urandom_range(0, 5)), int'($urandom_range(0, 5)),
                  int'($urandom_range(0, 3)));
      wr(8'($urandom_range(8'h16, 8'h1E)), 16'($urandom));
      m = 2'($urandom_range(1, 3));
      start_mask(m);
      check_all("R3");
      ticks = int'($urandom_range(5, 40));
      for (int t = 0; t < ticks; t++) begin
        int gap;
        gap = int'($urandom_range(0, 3));
        repeat (gap) @(negedge clk);
        check_all("R8");
        do_tick(); k++;
        check_all("R3 R5 R6 R9");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule